// File: doc/BRIEF.md
# CCM Counter Block Generator

This block forms the 16-byte counter blocks that drive the keystream of the CCM authenticated cipher mode. A load strobe captures a length-field size parameter (L' = L - 1, where L is the width in bytes of the counter field) and a nonce. From these the block builds two values. The first is the counter-zero block, which is held aside for encrypting the authentication tag. The second is the running counter block, which starts at counter value one for the first payload block. Each step strobe then advances the running block by one.

The carry runs in big-endian order, from the last byte toward byte 0. An increment-mode input limits the carry to the low 32 bits, the low 64 bits or the whole 128 bits, or turns the increment off. When a step wraps the counter back to zero, the block raises a sticky overflow flag. It does not correct the counter. A following cipher engine uses the running block while the valid flag is high and pulses step once for each data block it consumes.

Top module: `ccm_ctr_gen`

## Requirements
- R1: After reset, ctr_valid_o and ovf_o are 0, and ctr_blk_o and ctr0_blk_o are all zeros.
- R2: A load sets ctr_valid_o one cycle later. Byte 0 of both output blocks (bits 127:120) is then {5'b00000, L'}, with L' taken from lprime_i at the load.
- R3: For a load with L = L'+1, block bytes 1 to 15-L take nonce bytes 0 to 14-L. Nonce byte k sits at nonce_i[111-8k -: 8], and block byte b sits at bits [127-8b -: 8]. Nonce bytes beyond 14-L have no effect on either block.
- R4: The counter field is block bytes 16-L to 15, big-endian. After a load it holds 0 in ctr0_blk_o and 1 in ctr_blk_o.
- R5: ctr0_blk_o changes only on a load. Steps leave it unchanged.
- R6: When inc_mode_i = 2'b00, a step leaves ctr_blk_o unchanged.
- R7: When inc_mode_i is 2'b01, 2'b10 or 2'b11, a step adds one to the low 32, 64 or 128 bits of ctr_blk_o, modulo that span. Bits above the span are left as they were. If the span is wider than the counter field, the carry continues into the nonce bytes.
- R8: ovf_o is set by a step with a non-zero span when the low min(span, 8L) bits of ctr_blk_o are all ones. It stays set until the next load, and a load clears it.
- R9: A step is ignored while ctr_valid_o is 0. When load_i and step_i are high together, the load takes effect and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture L' and nonce, and start a new counter sequence |
| lprime_i | input | 3 | Counter field width minus one, in bytes |
| nonce_i | input | 112 | Nonce bytes, byte 0 in the top bits |
| inc_mode_i | input | 2 | Increment span: 00 none, 01 low 32, 10 low 64, 11 all 128 bits |
| step_i | input | 1 | Advance the running counter by one |
| ctr_blk_o | output | 128 | Running counter block, byte 0 in the top bits |
| ctr_valid_o | output | 1 | Running counter block is valid |
| ctr0_blk_o | output | 128 | Counter-zero block, reserved for tag encryption |
| ovf_o | output | 1 | Sticky counter wrap indication |

## Verification
The hardest state to reach from the ports is a counter wrap, because the running counter can only be advanced one step per cycle from a starting value of one. The stimulus keeps the steps short by choosing a one-byte counter field (L' = 0), which wraps after 255 steps. A two-byte field (L' = 1) is also stepped 65535 times, so that the carry spills into the last nonce byte. In both cases the bench checks the cycle just before the wrap as well as the wrap itself, and it confirms that the flag stays set and is then cleared by a load.

// File: rtl/ccm_ctr_pkg.sv
package ccm_ctr_pkg;

  localparam int BLK_BYTES   = 16;
  localparam int BLK_W       = BLK_BYTES * 8;
  localparam int NONCE_BYTES = BLK_BYTES - 2;
  localparam int NONCE_W     = NONCE_BYTES * 8;
  localparam int LP_W        = 3;
  localparam int IDX_W       = 5;

  typedef enum logic [1:0] {
    SPAN_NONE = 2'b00,
    SPAN_32   = 2'b01,
    SPAN_64   = 2'b10,
    SPAN_ALL  = 2'b11
  } span_e;

  // Number of trailing bytes that an increment may touch.
  function automatic logic [IDX_W-1:0] span_bytes(input logic [1:0] mode);
    case (span_e'(mode))
      SPAN_32:  return 5'd4;
      SPAN_64:  return 5'd8;
      SPAN_ALL: return 5'd16;
      default:  return 5'd0;
    endcase
  endfunction

  // Counter field width in bytes, L = L' + 1.
  function automatic logic [IDX_W-1:0] field_bytes(input logic [LP_W-1:0] lp);
    return {2'b00, lp} + 5'd1;
  endfunction

  function automatic logic [IDX_W-1:0] min_bytes(input logic [IDX_W-1:0] a,
                                                 input logic [IDX_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/ccm_ctr_build.sv
module ccm_ctr_build
  import ccm_ctr_pkg::*;
(
  input  logic [LP_W-1:0]    lprime,
  input  logic [NONCE_W-1:0] nonce,
  output logic [BLK_W-1:0]   blk_zero,
  output logic [BLK_W-1:0]   blk_first
);

  logic [IDX_W-1:0] ctr_start;

  // First byte index that belongs to the counter field.
  assign ctr_start = 5'(BLK_BYTES) - field_bytes(lprime);

  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_byte
    localparam logic [IDX_W-1:0] BI = 5'(b);
    if (b == 0) begin : g_flags
      assign blk_zero[(BLK_BYTES-1-b)*8 +: 8]  = {5'b00000, lprime};
      assign blk_first[(BLK_BYTES-1-b)*8 +: 8] = {5'b00000, lprime};
    end else if (b == BLK_BYTES - 1) begin : g_last
      assign blk_zero[(BLK_BYTES-1-b)*8 +: 8]  = 8'h00;
      assign blk_first[(BLK_BYTES-1-b)*8 +: 8] = 8'h01;
    end else begin : g_mid
      logic       in_ctr;
      logic [7:0] nbyte;
      assign in_ctr = (BI >= ctr_start);
      assign nbyte  = nonce[(NONCE_BYTES-b)*8 +: 8];
      assign blk_zero[(BLK_BYTES-1-b)*8 +: 8]  = in_ctr ? 8'h00 : nbyte;
      assign blk_first[(BLK_BYTES-1-b)*8 +: 8] = in_ctr ? 8'h00 : nbyte;
    end
  end

endmodule

// File: rtl/ccm_ctr_inc.sv
module ccm_ctr_inc
  import ccm_ctr_pkg::*;
(
  input  logic [BLK_W-1:0] blk,
  input  logic [1:0]       mode,
  input  logic [LP_W-1:0]  lprime,
  output logic [BLK_W-1:0] nxt,
  output logic             wrap
);

  logic [IDX_W-1:0] sb;
  logic [IDX_W-1:0] lim;
  logic [IDX_W-1:0] span_start;
  logic [BLK_BYTES:0] carry;   // carry[b] = carry out of byte b toward byte b-1

  assign sb         = span_bytes(mode);
  assign lim        = min_bytes(sb, field_bytes(lprime));
  assign span_start = 5'(BLK_BYTES) - sb;
  assign carry[BLK_BYTES] = 1'b1;

  for (genvar b = BLK_BYTES - 1; b >= 0; b--) begin : g_byte
    localparam logic [IDX_W-1:0] BI = 5'(b);
    logic       in_span;
    logic [7:0] cur;
    assign in_span = (BI >= span_start);
    assign cur     = blk[(BLK_BYTES-1-b)*8 +: 8];
    assign nxt[(BLK_BYTES-1-b)*8 +: 8] = cur + {7'd0, in_span & carry[b+1]};
    assign carry[b] = in_span & carry[b+1] & (cur == 8'hFF);
  end

  // Wrap when the carry leaves the narrower of span and counter field.
  assign wrap = (lim != 5'd0) && carry[5'(BLK_BYTES) - lim];

endmodule

// File: rtl/ccm_ctr_gen.sv
module ccm_ctr_gen
  import ccm_ctr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [2:0]         lprime_i,
  input  logic [111:0]       nonce_i,
  input  logic [1:0]         inc_mode_i,
  input  logic               step_i,
  output logic [127:0]       ctr_blk_o,
  output logic               ctr_valid_o,
  output logic [127:0]       ctr0_blk_o,
  output logic               ovf_o
);

  logic [BLK_W-1:0] ctr_q, ctr0_q;
  logic             valid_q, ovf_q;
  logic [LP_W-1:0]  lp_q;

  logic [BLK_W-1:0] blk_zero, blk_first, blk_next;
  logic             wrap_evt;
  logic             step_take;
  logic             load_take;

  ccm_ctr_build u_build (
    .lprime    (lprime_i),
    .nonce     (nonce_i),
    .blk_zero  (blk_zero),
    .blk_first (blk_first)
  );

  ccm_ctr_inc u_inc (
    .blk    (ctr_q),
    .mode   (inc_mode_i),
    .lprime (lp_q),
    .nxt    (blk_next),
    .wrap   (wrap_evt)
  );

  assign load_take = load_i;
  assign step_take = step_i & valid_q & ~load_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr_q   <= '0;
      ctr0_q  <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
      lp_q    <= '0;
    end else if (load_take) begin
      ctr_q   <= blk_first;
      ctr0_q  <= blk_zero;
      valid_q <= 1'b1;
      ovf_q   <= 1'b0;
      lp_q    <= lprime_i;
    end else if (step_take) begin
      ctr_q <= blk_next;
      if (wrap_evt) ovf_q <= 1'b1;
    end
  end

  assign ctr_blk_o   = ctr_q;
  assign ctr0_blk_o  = ctr0_q;
  assign ctr_valid_o = valid_q;
  assign ovf_o       = ovf_q;

  p_load_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ctr_valid_o && ctr_blk_o[127:120] == {5'b00000, $past(lprime_i)});

  p_first_is_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ctr_blk_o == (ctr0_blk_o | 128'd1));

  p_ctr0_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(ctr0_blk_o));

  p_mode_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i && inc_mode_i == 2'b00 |=> $stable(ctr_blk_o));

  p_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i && inc_mode_i != 2'b11 |=> ctr_blk_o[127:64] == $past(ctr_blk_o[127:64]));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !load_i |=> ovf_o);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !ovf_o);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctr_valid_o && !load_i |=> !ctr_valid_o && $stable(ctr_blk_o));

endmodule

// File: tb/ccm_ctr_gen_bench.sv
module ccm_ctr_gen_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic [2:0]   lprime_i = '0;
  logic [111:0] nonce_i = '0;
  logic [1:0]   inc_mode_i = '0;
  logic         step_i = 1'b0;
  logic [127:0] ctr_blk_o, ctr0_blk_o;
  logic         ctr_valid_o, ovf_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ccm_ctr_gen u_ccm_ctr_gen (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .lprime_i(lprime_i),
    .nonce_i(nonce_i), .inc_mode_i(inc_mode_i), .step_i(step_i),
    .ctr_blk_o(ctr_blk_o), .ctr_valid_o(ctr_valid_o),
    .ctr0_blk_o(ctr0_blk_o), .ovf_o(ovf_o)
  );

  localparam logic [111:0] NBASE = 112'hA0A1A2A3A4A5A6A7A8A9AAABACAD;

  // {lprime, mode, steps, expected overflow}
  localparam logic [21:0] VECS [0:8] = '{
    {3'd7, 2'd1, 16'd5,   1'b0},
    {3'd1, 2'd2, 16'd3,   1'b0},
    {3'd3, 2'd0, 16'd4,   1'b0},
    {3'd2, 2'd3, 16'd10,  1'b0},
    {3'd5, 2'd1, 16'd300, 1'b0},
    {3'd4, 2'd2, 16'd256, 1'b0},
    {3'd6, 2'd3, 16'd0,   1'b0},
    {3'd0, 2'd1, 16'd255, 1'b1},
    {3'd0, 2'd3, 16'd254, 1'b0}
  };

  function automatic logic [127:0] m_build(input logic [2:0] lp, input logic [111:0] n,
                                           input logic [63:0] cnt);
    logic [127:0] r;
    int L;
    L = int'(lp) + 1;
    r = '0;
    for (int b = 0; b < 16; b++) begin
      logic [7:0] v;
      if (b == 0) v = {5'd0, lp};
      else if (b < 16 - L) v = n[111 - 8*(b-1) -: 8];
      else v = 8'(cnt >> (8 * (15 - b)));
      r[127 - 8*b -: 8] = v;
    end
    return r;
  endfunction

  function automatic logic [127:0] m_step(input logic [127:0] blk, input logic [1:0] mode);
    logic [127:0] mask;
    if (mode == 2'd0) return blk;
    if (mode == 2'd3) return blk + 128'd1;
    mask = (mode == 2'd1) ? {96'd0, {32{1'b1}}} : {64'd0, {64{1'b1}}};
    return (blk & ~mask) | ((blk + 128'd1) & mask);
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] lp, input logic [111:0] n);
    @(negedge clk);
    load_i = 1'b1; lprime_i = lp; nonce_i = n;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_steps(input logic [1:0] mode, input int n);
    if (n > 0) begin
      @(negedge clk);
      step_i = 1'b1; inc_mode_i = mode;
      repeat (n - 1) @(negedge clk);
      @(negedge clk);
      step_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] exp_blk, exp0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", {127'd0, ctr_valid_o}, 128'd0);
    chk("R1 ctr", ctr_blk_o, 128'd0);
    chk("R1 ctr0", ctr0_blk_o, 128'd0);
    chk("R1 ovf", {127'd0, ovf_o}, 128'd0);

    // R9 steps before any load are ignored
    do_steps(2'd3, 3);
    chk("R9 idle ctr", ctr_blk_o, 128'd0);
    chk("R9 idle valid", {127'd0, ctr_valid_o}, 128'd0);

    // Vector table: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 9; i++) begin
      logic [2:0] lp; logic [1:0] md; int n; logic eo; logic [111:0] nn;
      lp = VECS[i][21:19]; md = VECS[i][18:17]; n = int'(VECS[i][16:1]); eo = VECS[i][0];
      nn = NBASE + 112'(i * 7919);
      do_load(lp, nn);
      chk("R2 valid after load", {127'd0, ctr_valid_o}, 128'd1);
      exp0 = m_build(lp, nn, 64'd0);
      exp_blk = m_build(lp, nn, 64'd1);
      chk("R4 first block", ctr_blk_o, exp_blk);
      do_steps(md, n);
      for (int k = 0; k < n; k++) exp_blk = m_step(exp_blk, md);
      chk("R7 R6 stepped block", ctr_blk_o, exp_blk);
      chk("R5 R3 counter-zero block", ctr0_blk_o, exp0);
      chk("R8 overflow flag", {127'd0, ovf_o}, {127'd0, eo});
    end

    // R8 sticky and cleared by load (one-byte field)
    do_load(3'd0, NBASE);
    do_steps(2'd1, 254);
    chk("R8 no wrap at 0xFF", {127'd0, ovf_o}, 128'd0);
    do_steps(2'd1, 1);
    chk("R8 wrap sets flag", {127'd0, ovf_o}, 128'd1);
    do_steps(2'd1, 1);
    chk("R8 flag sticky", {127'd0, ovf_o}, 128'd1);
    do_load(3'd0, NBASE);
    chk("R8 load clears flag", {127'd0, ovf_o}, 128'd0);

    // R9 load wins over simultaneous step
    @(negedge clk);
    load_i = 1'b1; step_i = 1'b1; inc_mode_i = 2'd3; lprime_i = 3'd2; nonce_i = NBASE;
    @(negedge clk);
    load_i = 1'b0; step_i = 1'b0;
    chk("R9 load priority", ctr_blk_o, m_build(3'd2, NBASE, 64'd1));

    // R3 unused nonce bytes have no effect (L=8 uses nonce bytes 0..6)
    do_load(3'd7, NBASE);
    exp0 = ctr0_blk_o;
    do_load(3'd7, NBASE ^ {56'd0, {56{1'b1}}});
    chk("R3 unused nonce bytes", ctr0_blk_o, exp0);
    chk("R3 nonce placement", ctr0_blk_o, m_build(3'd7, NBASE, 64'd0));

    // R6 mode none
    do_steps(2'd0, 4);
    chk("R6 no increment", ctr_blk_o, m_build(3'd7, NBASE, 64'd1));

    // R7 R8 two-byte field wrap carrying into the nonce
    do_load(3'd1, NBASE);
    do_steps(2'd1, 65534);
    chk("R7 field at 0xFFFF", ctr_blk_o, m_build(3'd1, NBASE, 64'hFFFF));
    chk("R8 no wrap yet", {127'd0, ovf_o}, 128'd0);
    do_steps(2'd1, 1);
    chk("R7 carry into nonce", ctr_blk_o, m_step(m_build(3'd1, NBASE, 64'hFFFF), 2'd1));
    chk("R8 two-byte wrap", {127'd0, ovf_o}, 128'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule